// File: doc/BRIEF.md
# Three-Channel Successive-Approximation Offset Calibrator

This block drives the offset-trim DACs of three analog signal paths and finds, for each one, the code that brings its output closest to its reference without going above it. A single start bit launches the search on all three channels at once. Each channel has a comparator that reports whether the output sits above its reference. The search is binary and runs from the most significant bit down. Each of the seven trials waits a programmable number of settling clocks before the comparator is sampled.

While the search runs, the block asks the analog front end to short its differential inputs, unless a mode bit keeps the external inputs connected so that system-level offsets are trimmed as well. A separate force bit shorts the inputs at any time. When the search ends, a one-cycle done pulse clears the start bit in the register file. The three results stay in the block until the next run or the next reset.

Each channel has its own manual byte. When the top bit of that byte is set and no search is running, the DAC is given the byte's lower seven bits instead of the calibrated code.

The sequencer has five states:
- IDLE waits for a start edge.
- TRIAL sets the bit under test.
- SETTLE counts settling clocks.
- JUDGE samples the comparators and either moves to the next lower bit or ends the search.
- FINISH issues the done pulse and returns to IDLE.

The transitions are:
- IDLE→TRIAL on an accepted start.
- TRIAL→SETTLE always.
- SETTLE→JUDGE when the count reaches the programmed value.
- JUDGE→TRIAL while bits remain.
- JUDGE→FINISH after bit 0.
- FINISH→IDLE always.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: After reset every channel's DAC code is mid-scale 0x40, and busy, cal_done and short_inputs are 0.
- R2: A search gives each channel the largest 7-bit code for which its comparator does not report "above". The value cmp_hi=1 means the output is above its reference, so the bit under test is cleared. Bits are tried from bit 6 down to bit 0, so targets 0x00 and 0x7F are both reachable.
- R3: One start request searches all three channels in parallel, each from its own comparator, giving independent results.
- R4: A search is accepted on a 0-to-1 change of cal_go while idle. For a settle value S, busy then stays high for exactly 7*(S+3)+1 cycles. A cal_go level held high after completion does not start another search.
- R5: cal_done is high for exactly one cycle, in the last busy cycle, and busy is low in the cycle after it.
- R6: A start edge that arrives while a search is running has no effect: the run length and the results are unchanged.
- R7: With keep_inputs=0 at the start, short_inputs is high in every busy cycle. With keep_inputs=1 at the start, short_inputs stays low during the search. When idle and not forced, short_inputs is low.
- R8: force_short=1 drives short_inputs high regardless of busy or mode.
- R9: Channel c's manual byte is man_cfg[8c+7:8c]. When its bit 7 is 1 and the block is idle, dac_code[7c+6:7c] equals bits 6:0 of that byte. When bit 7 is 0, the calibrated code is output and bits 6:0 have no effect.
- R10: During a search each DAC carries the search code even if the channel's manual bit is set, and the calibrated result is stored for later use.
- R11: Calibrated codes persist unchanged through later idle periods and manual-mode episodes until the next search or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_go | input | 1 | Start bit from the register file; a rising edge while idle starts a search |
| keep_inputs | input | 1 | Search mode: 1 keeps external inputs connected during the search |
| force_short | input | 1 | Shorts the inputs unconditionally |
| settle_cycles | input | SETTLE_W | Extra settling clocks per bit trial |
| cmp_hi | input | NUM_CH | Per-channel comparator: 1 means the output is above its reference |
| man_cfg | input | NUM_CH*(CODE_W+1) | Per-channel manual byte: bit 7 is the enable, bits 6:0 are the code |
| dac_code | output | NUM_CH*CODE_W | Per-channel offset DAC code |
| short_inputs | output | 1 | Request to short the differential inputs |
| busy | output | 1 | A search is in progress |
| cal_done | output | 1 | One-cycle completion pulse that clears the start bit |

## Verification
The hardest case to reach from the ports is a second start edge that lands inside a search. In a system the start bit stays high until the done pulse clears it. The bench therefore lowers cal_go and raises it again at a chosen busy cycle, in the middle of a settling window. It then checks that the run length and all three codes match an undisturbed run. The bench's comparator model is closed around dac_code, with a separate threshold per channel. Thresholds at 0x00, 0x7F and irregular values exercise every keep/clear decision in the search.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_SETTLE,
        ST_JUDGE,
        ST_FINISH
    } cal_state_e;
endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                keep_mode,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                start_p,
    output logic                trial_p,
    output logic                judge_p,
    output logic [CODE_W-1:0]   bit_sel,
    output logic                busy,
    output logic                done,
    output logic                keep_lat
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    cal_state_e          state_q, state_d;
    logic                go_q;
    logic [IDX_W-1:0]    bit_idx;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                go_edge;

    assign go_edge = go & ~go_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_edge) state_d = ST_TRIAL;
            ST_TRIAL:  state_d = ST_SETTLE;
            ST_SETTLE: if (settle_cnt == settle_cycles) state_d = ST_JUDGE;
            ST_JUDGE:  state_d = (bit_idx == '0) ? ST_FINISH : ST_TRIAL;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_p = 1'b0;
        trial_p = 1'b0;
        judge_p = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; start_p = go_edge; end
            ST_TRIAL:  trial_p = 1'b1;
            ST_SETTLE: ;
            ST_JUDGE:  judge_p = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign bit_sel = CODE_W'(1) << bit_idx;

    // datapath: edge history, bit pointer, settle timer, mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            bit_idx    <= TOP_IDX;
            settle_cnt <= '0;
            keep_lat   <= 1'b0;
        end else begin
            go_q <= go;
            if (start_p) begin
                bit_idx  <= TOP_IDX;
                keep_lat <= keep_mode;
            end else if (judge_p && bit_idx != '0) begin
                bit_idx <= bit_idx - 1'b1;
            end
            if (trial_p)                   settle_cnt <= '0;
            else if (state_q == ST_SETTLE) settle_cnt <= settle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ofs_sar_chan.sv
module ofs_sar_chan #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              trial_p,
    input  logic              judge_p,
    input  logic [CODE_W-1:0] bit_sel,
    input  logic              cmp_hi,
    input  logic              busy,
    input  logic              man_en,
    input  logic [CODE_W-1:0] man_code,
    output logic [CODE_W-1:0] dac
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] cal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cal_q <= MID;
        else if (start_p)           cal_q <= '0;
        else if (trial_p)           cal_q <= cal_q | bit_sel;
        else if (judge_p && cmp_hi) cal_q <= cal_q & ~bit_sel;
    end

    assign dac = (man_en && !busy) ? man_code : cal_q;
endmodule

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl #(
    parameter int NUM_CH   = 3,
    parameter int CODE_W   = 7,
    parameter int SETTLE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_go,
    input  logic                         keep_inputs,
    input  logic                         force_short,
    input  logic [SETTLE_W-1:0]          settle_cycles,
    input  logic [NUM_CH-1:0]            cmp_hi,
    input  logic [NUM_CH*(CODE_W+1)-1:0] man_cfg,
    output logic [NUM_CH*CODE_W-1:0]     dac_code,
    output logic                         short_inputs,
    output logic                         busy,
    output logic                         cal_done
);
    localparam int MAN_W = CODE_W + 1;

    logic              start_p, trial_p, judge_p, keep_lat;
    logic [CODE_W-1:0] bit_sel;

    ofs_cal_seq #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(cal_go), .keep_mode(keep_inputs),
        .settle_cycles(settle_cycles), .start_p(start_p), .trial_p(trial_p),
        .judge_p(judge_p), .bit_sel(bit_sel), .busy(busy), .done(cal_done),
        .keep_lat(keep_lat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ofs_sar_chan #(.CODE_W(CODE_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .start_p(start_p), .trial_p(trial_p),
            .judge_p(judge_p), .bit_sel(bit_sel), .cmp_hi(cmp_hi[c]), .busy(busy),
            .man_en(man_cfg[c*MAN_W + CODE_W]),
            .man_code(man_cfg[c*MAN_W +: CODE_W]),
            .dac(dac_code[c*CODE_W +: CODE_W])
        );
    end

    assign short_inputs = force_short | (busy & ~keep_lat);
endmodule

// File: rtl/ofs_cal_chk.sv
module ofs_cal_chk #(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 7
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         force_short,
    input logic [NUM_CH*(CODE_W+1)-1:0] man_cfg,
    input logic [NUM_CH*CODE_W-1:0]     dac_code,
    input logic                         short_inputs,
    input logic                         busy,
    input logic                         cal_done
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);
    // R5
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !busy);
    // R5
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> busy);
    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_done) |=> busy);
    // R8
    force_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_short |-> short_inputs);
    // R7
    idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !force_short) |-> !short_inputs);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_man
        // R9
        manual_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && man_cfg[c*(CODE_W+1) + CODE_W]) |->
            (dac_code[c*CODE_W +: CODE_W] == man_cfg[c*(CODE_W+1) +: CODE_W]));
    end
endmodule

bind ofs_cal_ctrl ofs_cal_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_short(force_short), .man_cfg(man_cfg),
    .dac_code(dac_code), .short_inputs(short_inputs), .busy(busy),
    .cal_done(cal_done)
);

// File: tb/ofs_cal_ctrl_tb.sv
module ofs_cal_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int CW  = 7;
    localparam int SW  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cal_go = 1'b0;
    logic                  keep_inputs = 1'b0;
    logic                  force_short = 1'b0;
    logic [SW-1:0]         settle_cycles = 8'd2;
    logic [NCH-1:0]        cmp_hi;
    logic [NCH*(CW+1)-1:0] man_cfg = '0;
    logic [NCH*CW-1:0]     dac_code;
    logic                  short_inputs, busy, cal_done;
    logic [CW-1:0]         tgt [NCH];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // comparator model: output above reference when DAC code exceeds threshold
    always_comb
        for (int c = 0; c < NCH; c++)
            cmp_hi[c] = dac_code[c*CW +: CW] > tgt[c];

    ofs_cal_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cal_go(cal_go), .keep_inputs(keep_inputs),
        .force_short(force_short), .settle_cycles(settle_cycles), .cmp_hi(cmp_hi),
        .man_cfg(man_cfg), .dac_code(dac_code), .short_inputs(short_inputs),
        .busy(busy), .cal_done(cal_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int code_of(input int c);
        return int'(dac_code[c*CW +: CW]);
    endfunction

    // runs one search; poke_at>0 makes a start edge inside the run
    task automatic run_cal(input int s, input bit keep, input int poke_at,
                           input bit hold_go, output int nbusy, output int ndone,
                           output int short_bad);
        int n = 0;
        @(negedge clk);
        settle_cycles = SW'(s);
        keep_inputs = keep;
        cal_go = 1'b1;
        nbusy = 0; ndone = 0; short_bad = 0;
        while (n < 2000) begin
            @(negedge clk);
            n++;
            if (!busy) break;
            nbusy++;
            if (short_inputs != !keep) short_bad++;
            if (poke_at > 0 && nbusy == poke_at)     cal_go = 1'b0;
            if (poke_at > 0 && nbusy == poke_at + 2) cal_go = 1'b1;
            if (cal_done) begin
                ndone++;
                if (!hold_go) cal_go = 1'b0;
            end
        end
    endtask

    task automatic t_reset;
        for (int c = 0; c < NCH; c++)
            chk(code_of(c) == 'h40, "R1 mid-scale code", code_of(c), 'h40);
        chk(!busy && !cal_done && !short_inputs, "R1 idle outputs",
            {busy, cal_done, short_inputs}, 0);
    endtask

    task automatic t_basic(input int s, input int a, input int b, input int g);
        int nb, nd, sb;
        tgt[0] = CW'(a); tgt[1] = CW'(b); tgt[2] = CW'(g);
        run_cal(s, 1'b0, 0, 1'b0, nb, nd, sb);
        chk(nb == 7*(s+3)+1, "R4 busy length", nb, 7*(s+3)+1);
        chk(nd == 1, "R5 single done pulse", nd, 1);
        chk(sb == 0, "R7 shorted while busy", sb, 0);
        chk(!short_inputs, "R7 released after run", short_inputs, 0);
        chk(code_of(0) == a, "R2 channel 0 result", code_of(0), a);
        chk(code_of(1) == b, "R3 channel 1 result", code_of(1), b);
        chk(code_of(2) == g, "R3 channel 2 result", code_of(2), g);
    endtask

    task automatic t_keep;
        int nb, nd, sb;
        tgt[0] = 7'h11; tgt[1] = 7'h22; tgt[2] = 7'h44;
        run_cal(1, 1'b1, 0, 1'b0, nb, nd, sb);
        chk(sb == 0, "R7 inputs kept connected", sb, 0);
        chk(code_of(2) == 'h44, "R2 keep-mode result", code_of(2), 'h44);
    endtask

    task automatic t_force;
        @(negedge clk); force_short = 1'b1;
        @(negedge clk);
        chk(short_inputs, "R8 forced short idle", short_inputs, 1);
        @(negedge clk); force_short = 1'b0;
        @(negedge clk);
        chk(!short_inputs, "R8 force released", short_inputs, 0);
    endtask

    task automatic t_ignore;
        int nb, nd, sb;
        tgt[0] = 7'h5A; tgt[1] = 7'h01; tgt[2] = 7'h7E;
        run_cal(3, 1'b0, 10, 1'b1, nb, nd, sb);
        chk(nb == 7*6+1, "R6 run length unchanged", nb, 43);
        chk(nd == 1, "R6 one done pulse", nd, 1);
        chk(code_of(0) == 'h5A && code_of(2) == 'h7E, "R6 results unchanged",
            code_of(0), 'h5A);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!busy, "R4 held level does not restart", busy, 0);
        end
        cal_go = 1'b0;
    endtask

    task automatic t_manual;
        int nb, nd, sb;
        // channel 1 manual on, channel 0 manual off with junk code bits
        @(negedge clk);
        man_cfg = {8'h00, 8'h80 | 8'h15, 8'h00 | 8'h6B};
        @(negedge clk);
        chk(code_of(1) == 'h15, "R9 manual code selected", code_of(1), 'h15);
        chk(code_of(0) == 'h5A, "R9 low bits ignored without enable", code_of(0), 'h5A);
        chk(code_of(2) == 'h7E, "R11 code retained", code_of(2), 'h7E);
        // search with manual set on channel 1
        tgt[0] = 7'h30; tgt[1] = 7'h33; tgt[2] = 7'h0C;
        run_cal(0, 1'b0, 0, 1'b0, nb, nd, sb);
        chk(nb == 22, "R4 zero-settle length", nb, 22);
        chk(code_of(1) == 'h15, "R9 manual after run", code_of(1), 'h15);
        @(negedge clk); man_cfg = '0;
        @(negedge clk);
        chk(code_of(1) == 'h33, "R10 search ran under manual", code_of(1), 'h33);
        chk(code_of(2) == 'h0C, "R3 channel 2 result", code_of(2), 'h0C);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tgt[0] = '0; tgt[1] = '0; tgt[2] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(2, 'h00, 'h7F, 'h2D);
        t_basic(5, 'h40, 'h3F, 'h55);
        t_keep();
        t_force();
        t_ignore();
        t_manual();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule